// File: doc/BRIEF.md
# Capture Timer Channel with Deferred Overflow Flag

This block is one up-counting timer channel driven by a 3-bit operating-mode input. Two of the mode codes select capture behaviour. In those modes the counter starts at zero and advances on each clock where the count enable is high. A capture strobe copies the current count into a capture register and restarts the counter from zero.

A status word reports whether the counter rolled over between two captures. A rollover does not change the status word when it happens. It only arms a hidden pending bit. The visible flag is refreshed at the next capture. That capture sets the flag when a rollover was pending and clears it when none was, whatever value the flag held before.

In every other mode code the flag is inert: it reads as zero and capture strobes are ignored. Software reads the full 16-bit status word or a byte-wide view of its low half.

Top module: `cap_timer_chan`

## Requirements
- R1: After reset the status word reads 0000h, the byte view reads 00h and the capture register reads 0.
- R2: In mode 010b or 110b the counter starts at 0 and advances by one on each clock with the count enable high, wrapping from all-ones to 0.
- R3: A capture strobe in a capture mode loads the current count into the capture register, visible one clock later, and the counter restarts from 0 in that clock.
- R4: A capture sets status bit 0 to 1 when the counter wrapped at least once since the previous capture, or since the last mode change.
- R5: A capture clears status bit 0 to 0 when no wrap occurred since the previous capture, even if the bit was 1.
- R6: Status bit 0 changes only on a capture or a mode change; a wrap alone leaves it unchanged.
- R7: A wrap in the same clock as a capture (count at all-ones, enable high, strobe high) counts toward that capture. The captured value is all-ones and the flag becomes 1.
- R8: In any mode code other than 010b and 110b, status bit 0 stays 0 and capture strobes leave the capture register unchanged.
- R9: A change of the mode input clears status bit 0, the pending wrap and the counter in that clock. A capture in that clock is ignored.
- R10: Status bits 15 to 1 always read 0. The byte view always equals status bits 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating-mode code; 010b and 110b select capture |
| cnt_en_i | input | 1 | Count enable |
| cap_i | input | 1 | Capture strobe |
| cap_val_o | output | CNT_W | Capture register |
| stat_o | output | 16 | Status word; bit 0 is the overflow flag |
| stat_lo_o | output | 8 | Byte-wide view of status bits 7 to 0 |

## Verification
On every cycle, the assertions check the following. The flag holds its value when there is neither a capture nor a mode change. A wrap without a capture arms the pending bit. Each capture copies the pending state into the flag and restarts the counter. A mode change clears the flag and the pending bit. Non-capture modes keep the flag at zero and the capture register still. The upper status bits stay zero.

Only the bench scenarios show the end-to-end timing. They sweep the number of counts between captures past the wrap point in both capture modes and check the captured values arithmetically. They also check that a flag of 1 is cleared by a later capture with no wrap, that a wrap in the same clock as a capture counts toward it, and that a wrap left pending is dropped across a mode switch.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int MODE_W = 3;
  localparam int STAT_W = 16;
  localparam int STAT_LO_W = 8;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_CAPTURE  = 3'b010;
  localparam mode_t MODE_CAP_ONCE = 3'b110;

  // True for the two mode codes in which the overflow flag is live.
  function automatic logic is_capture_mode(mode_t m);
    return (m == MODE_CAPTURE) || (m == MODE_CAP_ONCE);
  endfunction

  // Status word layout: flag in bit 0, every other bit zero.
  function automatic logic [STAT_W-1:0] pack_status(logic flag);
    logic [STAT_W-1:0] w;
    w = '0;
    w[0] = flag;
    return w;
  endfunction

endpackage

// File: rtl/cap_timer_mode.sv
module cap_timer_mode
  import cap_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_i,
  output logic  run_o,
  output logic  chg_o
);

  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_i;
  end

  assign chg_o = (mode_i != mode_q);
  assign run_o = is_capture_mode(mode_i);

endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] c);
    return c + CNT_ONE;
  endfunction

  assign adv    = run_i && en_i;
  assign wrap_o = adv && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv) cnt_q <= step_count(cnt_q);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cap_timer_ovf.sv
module cap_timer_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic wrap_i,
  input  logic cap_i,
  input  logic chg_i,
  output logic pend_o,
  output logic flag_o
);

  logic pend_q;
  logic flag_q;

  // Pending wrap: armed by a rollover, consumed by a capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (chg_i)  pend_q <= 1'b0;
    else if (cap_i)  pend_q <= 1'b0;
    else if (wrap_i) pend_q <= 1'b1;
  end

  // Visible flag: refreshed only at capture; a same-cycle wrap counts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (chg_i || !run_i) flag_q <= 1'b0;
    else if (cap_i)          flag_q <= pend_q || wrap_i;
  end

  assign pend_o = pend_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             cnt_en_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic [15:0]      stat_o,
  output logic [7:0]       stat_lo_o
);

  // Named internal events, observed by the bound checker.
  logic             run;
  logic             mode_chg;
  logic             cap_evt;
  logic             wrap_evt;
  logic             pend_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;

  cap_timer_mode mode_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .run_o  (run),
    .chg_o  (mode_chg)
  );

  assign cap_evt = run && cap_i && !mode_chg;

  cap_timer_counter #(.CNT_W(CNT_W)) cnt_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run && !mode_chg),
    .en_i   (cnt_en_i),
    .clr_i  (mode_chg || cap_evt),
    .cnt_o  (cnt_q),
    .wrap_o (wrap_evt)
  );

  cap_timer_ovf ovf_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .wrap_i (wrap_evt),
    .cap_i  (cap_evt),
    .chg_i  (mode_chg),
    .pend_o (pend_q),
    .flag_o (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  assign cap_val_o = cap_q;
  assign stat_o    = pack_status(flag_q);
  assign stat_lo_o = stat_o[STAT_LO_W-1:0];

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic [15:0]      stat_o,
  input logic             mode_chg,
  input logic             cap_evt,
  input logic             wrap_evt,
  input logic             pend_q,
  input logic [CNT_W-1:0] cnt_q
);

  // R10: upper status bits never set
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[15:1] == 15'd0);

  // R8: other modes keep the flag at zero and the capture register still
  a_r8_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !is_capture_mode(mode_i) |=> (stat_o[0] == 1'b0) && $stable(cap_val_o));

  // R6: flag moves only on capture or mode change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !mode_chg) |=> $stable(stat_o[0]));

  // R6: a wrap without capture arms the pending bit
  a_r6_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !cap_evt && !mode_chg) |=> pend_q);

  // R4, R5, R7: capture copies pending state (including same-cycle wrap)
  a_r4_sample: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (stat_o[0] == $past(pend_q || wrap_evt)) && !pend_q);

  // R3: capture latches the count and restarts the counter
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cnt_q == '0) && (cap_val_o == $past(cnt_q)));

  // R9: mode change clears flag, pending wrap and counter
  a_r9_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (stat_o[0] == 1'b0) && !pend_q && (cnt_q == '0));

endmodule

bind cap_timer_chan cap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .cap_val_o (cap_val_o),
  .stat_o    (stat_o),
  .mode_chg  (mode_chg),
  .cap_evt   (cap_evt),
  .wrap_evt  (wrap_evt),
  .pend_q    (pend_q),
  .cnt_q     (cnt_q)
);

// File: tb/cap_timer_chan_tb_top.sv
module cap_timer_chan_tb_top;

  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode = 3'b010;
  logic         en = 1'b0;
  logic         cap = 1'b0;
  logic [W-1:0] cap_val;
  logic [15:0]  stat;
  logic [7:0]   stat_lo;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_cap = '0;
  logic         exp_flag = 1'b0;
  logic         done = 1'b0;

  always #5 clk = ~clk;

  cap_timer_chan #(.CNT_W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .cnt_en_i  (en),
    .cap_i     (cap),
    .cap_val_o (cap_val),
    .stat_o    (stat),
    .stat_lo_o (stat_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge later the results are sampled.
  task automatic cyc(input logic e, input logic c);
    en  = e;
    cap = c;
    @(negedge clk);
    en  = 1'b0;
    cap = 1'b0;
  endtask

  task automatic check_status(input string req);
    chk(req, int'(stat), int'({15'd0, exp_flag}));
    chk("R10", int'(stat_lo), int'({7'd0, exp_flag}));
  endtask

  // k counting clocks, then a capture clock with enable low.
  task automatic run_and_capture(input int k, input string req);
    for (int i = 0; i < k; i++) cyc(1'b1, 1'b0);
    chk("R6", int'(stat[0]), int'(exp_flag));
    cyc(1'b0, 1'b1);
    exp_cap  = W'(k % SPAN);
    exp_flag = (k >= SPAN);
    chk("R3", int'(cap_val), int'(exp_cap));
    check_status(req);
  endtask

  task automatic switch_mode(input logic [2:0] m);
    mode = m;
    cyc(1'b0, 1'b0);
    exp_flag = 1'b0;
    check_status("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(stat), 0);
    chk("R1", int'(stat_lo), 0);
    chk("R1", int'(cap_val), 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);
    check_status("R1");

    // R2 R3 R4 R5: sweep counts across the wrap point, both capture modes
    for (int mi = 0; mi < 2; mi++) begin
      switch_mode(mi == 0 ? 3'b010 : 3'b110);
      for (int k = 0; k <= 2 * SPAN + 4; k++) begin
        run_and_capture(k, k >= SPAN ? "R4" : "R2");
        run_and_capture(1, "R5");
      end
    end

    // R7: wrap in the capture clock counts toward it
    switch_mode(3'b010);
    for (int i = 0; i < SPAN - 1; i++) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    exp_cap = W'(SPAN - 1);
    exp_flag = 1'b1;
    chk("R7", int'(cap_val), int'(exp_cap));
    check_status("R7");
    run_and_capture(0, "R5");
    for (int i = 0; i < SPAN - 2; i++) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    exp_cap = W'(SPAN - 2);
    exp_flag = 1'b0;
    chk("R7", int'(cap_val), int'(exp_cap));
    check_status("R7");

    // R9: a flag of 1 and a pending wrap are both dropped by a mode switch
    run_and_capture(SPAN + 3, "R4");
    for (int i = 0; i < SPAN + 2; i++) cyc(1'b1, 1'b0);
    chk("R6", int'(stat[0]), 1);
    switch_mode(3'b110);
    run_and_capture(3, "R9");

    // R8: all non-capture codes ignore strobes and keep the flag low
    run_and_capture(SPAN + 1, "R4");
    for (int m = 0; m < 8; m++) begin
      if (m == 2 || m == 6) continue;
      switch_mode(3'(m));
      for (int i = 0; i < 2 * SPAN + 3; i++) begin
        cyc(1'b1, i[0]);
        chk("R8", int'(stat), 0);
        chk("R8", int'(cap_val), int'(exp_cap));
      end
    end

    // Back in capture mode the counter restarts from zero
    switch_mode(3'b010);
    run_and_capture(5, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule